// File: doc/BRIEF.md
# Chained SPI DAC Loader

This block sends a burst of pre-formatted 32-bit command words over a write-only SPI link to converters wired in daisy chains. Software fills a small word store through a register bus, chooses which of the chip-select lines are active, and then writes a word count. That last write starts the burst. The count may come last in one run of back-to-back writes, so a single burst of bus cycles sets up and launches a transfer.

The serial clock comes from dividing the system clock. The data line and the clock are shared by all chains. A chip-select output is driven low for every chain whose mask bit is set, and it stays low for the whole burst. Each converter latches its word when its select rises. When the burst starts, the word store and the mask are copied, so software may prepare the next burst while the current one is still shifting.

Top module: `spi_chain_loader`

## Requirements
- R1: After reset every chip-select output is high, the serial clock is low and busy is low. While busy is low the clock stays low and all selects stay high.
- R2: The bus map is as follows. Offsets 0 to 15 hold the data words. Offset 16 holds the chain mask (bit i drives select i). Offset 17 holds the word count. Offset 18 is a read-only status word with busy in bit 0. Every read or accepted write is answered by a one-cycle acknowledge on the clock edge after the request, and a read returns its data together with that acknowledge.
- R3: A nonzero count write while idle is acknowledged and starts a burst. Busy rises on the same edge as the acknowledge. Count values above 16 send 16 words.
- R4: A count write while busy is answered with the no-more-data response instead of an acknowledge, and it leaves the running burst unchanged.
- R5: A count write of zero is acknowledged and starts nothing.
- R6: A burst sends the words at offsets 0 up to count-1 in that order. Each word goes most significant bit first, starting at bit 31, for count times 32 rising clock edges.
- R7: The link uses SPI mode 0. The clock idles low, the data line changes only while the clock is low, and the receiver samples on the rising edge.
- R8: For the whole burst, select i is low exactly when mask bit i is set. The selects fall one half period before the first rising edge and rise one half period after the last falling edge.
- R9: Each clock high phase and each low phase between rising edges lasts SCK_HALF system cycles.
- R10: After the selects rise, busy stays high for two more half periods, which gives a full idle clock period before the next burst can start.
- R11: Writes to the data words or the mask during a burst do not change that burst. They take effect in the next burst.
- R12: Eighteen back-to-back writes (16 data words, the mask, then the count) are all acknowledged and start the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with the acknowledge |
| bus_ack | output | 1 | Access accepted |
| bus_nomore | output | 1 | Count write refused because a burst is running |
| busy | output | 1 | Burst in progress, including the trailing gap |
| spi_sck | output | 1 | Serial clock shared by all chains |
| spi_mosi | output | 1 | Serial data shared by all chains |
| spi_cs_n | output | CHAINS | Active-low chain selects |

## Verification
If the shift engine holds a wrong bit index or a wrong word count, the rising-edge count at the ports changes, and the captured bit stream differs from the stored words within a single burst. A faulty phase counter shows up in the first high or low phase as a span other than SCK_HALF cycles. A missing or stale start-time copy shows up when the data or the mask is rewritten during a burst, because the select pattern or the later bits of that same burst then change. Errors in the handshake path show up one cycle after the count write, as a wrong acknowledge or no-more-data response.

// File: rtl/spi_loader_pkg.sv
package spi_loader_pkg;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_LEAD,
    ENG_HIGH,
    ENG_LOW,
    ENG_TAIL,
    ENG_GAP1,
    ENG_GAP2
  } eng_state_t;

  // Number of words a count write really sends: values above the store size saturate.
  function automatic int unsigned clamp_words(input logic [31:0] req, input int unsigned depth);
    if (req > depth) return depth;
    return req;
  endfunction

  // Rising edges a burst of n words produces.
  function automatic int unsigned burst_edges(input int unsigned n, input int unsigned w);
    return n * w;
  endfunction

  // True when the bit on the line is the final bit of the final word.
  function automatic logic final_bit(input int unsigned bits_left, input int unsigned words_left);
    return (bits_left == 0) && (words_left == 0);
  endfunction

endpackage

// File: rtl/spi_loader_regs.sv
module spi_loader_regs #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 16,
  parameter int CHAINS = 16,
  parameter int ADDR_W = 5,
  parameter int LEN_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic                    busy,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    bus_ack,
  output logic                    bus_nomore,
  output logic [WORDS*DATA_W-1:0] mem_flat,
  output logic [CHAINS-1:0]       chain_mask,
  output logic                    start,
  output logic [LEN_W-1:0]        start_len
);
  import spi_loader_pkg::*;

  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(WORDS);
  localparam logic [ADDR_W-1:0] LEN_A  = ADDR_W'(WORDS + 1);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(WORDS + 2);

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [CHAINS-1:0] mask_q;
  logic [DATA_W-1:0] len_q;
  logic [DATA_W-1:0] rd_mux;

  logic is_mem, len_hit, refuse;
  assign is_mem  = bus_addr < MASK_A;
  assign len_hit = bus_wr && (bus_addr == LEN_A);
  assign refuse  = len_hit && busy;
  assign start   = len_hit && !busy && (bus_wdata != '0);
  assign start_len = LEN_W'(clamp_words(bus_wdata, WORDS));

  always_comb begin
    rd_mux = '0;
    if (is_mem)                 rd_mux = mem_q[bus_addr[IDX_W-1:0]];
    else if (bus_addr == MASK_A) rd_mux = DATA_W'(mask_q);
    else if (bus_addr == LEN_A)  rd_mux = len_q;
    else if (bus_addr == STAT_A) rd_mux = DATA_W'(busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
      mask_q     <= '0;
      len_q      <= '0;
      bus_ack    <= 1'b0;
      bus_nomore <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_ack    <= (bus_wr || bus_rd) && !refuse;
      bus_nomore <= refuse;
      bus_rdata  <= bus_rd ? rd_mux : '0;
      if (bus_wr && is_mem)               mem_q[bus_addr[IDX_W-1:0]] <= bus_wdata;
      if (bus_wr && bus_addr == MASK_A)   mask_q <= bus_wdata[CHAINS-1:0];
      if (len_hit && !busy)               len_q  <= bus_wdata;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_flat
    assign mem_flat[g*DATA_W +: DATA_W] = mem_q[g];
  end

  assign chain_mask = mask_q;

endmodule

// File: rtl/spi_loader_clkgen.sv
module spi_loader_clkgen #(
  parameter int SCK_HALF = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SCK_HALF - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/spi_loader_engine.sv
module spi_loader_engine #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 16,
  parameter int CHAINS = 16,
  parameter int LEN_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [LEN_W-1:0]        start_len,
  input  logic [WORDS*DATA_W-1:0] mem_flat,
  input  logic [CHAINS-1:0]       chain_mask,
  input  logic                    tick,
  output logic                    sck,
  output logic                    mosi,
  output logic [CHAINS-1:0]       cs_n,
  output logic                    run,
  output logic                    bit_rise,
  output logic                    burst_end
);
  import spi_loader_pkg::*;

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int REST_W = WORDS * DATA_W;

  eng_state_t        state_q;
  logic [DATA_W-1:0] cur_q;
  logic [REST_W-1:0] rest_q;
  logic [BIT_W-1:0]  bits_left_q;
  logic [LEN_W-1:0]  words_left_q;
  logic              sck_q;
  logic [CHAINS-1:0] cs_q;
  logic              at_end;

  assign at_end    = final_bit(bits_left_q, words_left_q);
  assign run       = (state_q != ENG_IDLE);
  assign bit_rise  = tick && (state_q == ENG_LEAD || state_q == ENG_LOW);
  assign burst_end = tick && (state_q == ENG_GAP2);
  assign sck       = sck_q;
  assign mosi      = cur_q[DATA_W-1];
  assign cs_n      = cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ENG_IDLE;
      cur_q        <= '0;
      rest_q       <= '0;
      bits_left_q  <= '0;
      words_left_q <= '0;
      sck_q        <= 1'b0;
      cs_q         <= '1;
    end else begin
      unique case (state_q)
        ENG_IDLE: if (start) begin
          cur_q        <= mem_flat[DATA_W-1:0];
          rest_q       <= mem_flat >> DATA_W;
          bits_left_q  <= BIT_W'(DATA_W - 1);
          words_left_q <= start_len - 1'b1;
          cs_q         <= ~chain_mask;
          state_q      <= ENG_LEAD;
        end
        ENG_LEAD, ENG_LOW: if (tick) begin
          sck_q   <= 1'b1;
          state_q <= ENG_HIGH;
        end
        ENG_HIGH: if (tick) begin
          sck_q <= 1'b0;
          if (at_end) begin
            state_q <= ENG_TAIL;
          end else begin
            state_q <= ENG_LOW;
            if (bits_left_q == '0) begin
              cur_q        <= rest_q[DATA_W-1:0];
              rest_q       <= rest_q >> DATA_W;
              words_left_q <= words_left_q - 1'b1;
              bits_left_q  <= BIT_W'(DATA_W - 1);
            end else begin
              cur_q       <= cur_q << 1;
              bits_left_q <= bits_left_q - 1'b1;
            end
          end
        end
        ENG_TAIL: if (tick) begin
          cs_q    <= '1;
          cur_q   <= '0;
          state_q <= ENG_GAP1;
        end
        ENG_GAP1: if (tick) state_q <= ENG_GAP2;
        ENG_GAP2: if (tick) state_q <= ENG_IDLE;
        default:  state_q <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_chain_loader.sv
module spi_chain_loader #(
  parameter int DATA_W   = 32,
  parameter int WORDS    = 16,
  parameter int CHAINS   = 16,
  parameter int SCK_HALF = 8,
  localparam int ADDR_W  = $clog2(WORDS + 3),
  localparam int LEN_W   = $clog2(WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              bus_nomore,
  output logic              busy,
  output logic              spi_sck,
  output logic              spi_mosi,
  output logic [CHAINS-1:0] spi_cs_n
);

  logic [WORDS*DATA_W-1:0] mem_flat;
  logic [CHAINS-1:0]       chain_mask;
  logic                    start_evt;
  logic [LEN_W-1:0]        start_len;
  logic                    tick;
  logic                    run;
  logic                    bit_rise;
  logic                    burst_end;

  spi_loader_regs #(
    .DATA_W(DATA_W), .WORDS(WORDS), .CHAINS(CHAINS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy(run),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_nomore(bus_nomore),
    .mem_flat(mem_flat), .chain_mask(chain_mask),
    .start(start_evt), .start_len(start_len)
  );

  spi_loader_clkgen #(.SCK_HALF(SCK_HALF)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  spi_loader_engine #(
    .DATA_W(DATA_W), .WORDS(WORDS), .CHAINS(CHAINS), .LEN_W(LEN_W)
  ) engine_i (
    .clk(clk), .rst_n(rst_n),
    .start(start_evt), .start_len(start_len),
    .mem_flat(mem_flat), .chain_mask(chain_mask),
    .tick(tick),
    .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .run(run), .bit_rise(bit_rise), .burst_end(burst_end)
  );

  assign busy = run;

endmodule

// File: rtl/spi_loader_checker.sv
module spi_loader_checker #(
  parameter int DATA_W = 32,
  parameter int CHAINS = 16,
  parameter int ADDR_W = 5,
  parameter int LEN_A  = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack,
  input logic              bus_nomore,
  input logic              busy,
  input logic              sck,
  input logic              mosi,
  input logic [CHAINS-1:0] cs_n,
  input logic              start_evt,
  input logic              bit_rise
);
  logic len_wr;
  assign len_wr = bus_wr && (bus_addr == ADDR_W'(LEN_A));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck && (&cs_n)));

  assert_resp_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ack && bus_nomore));

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy && bus_ack));

  assert_refuse_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (len_wr && busy) |=> (bus_nomore && !bus_ack));

  assert_zero_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (len_wr && !busy && bus_wdata == '0) |=> (bus_ack && !busy));

  assert_mosi_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  assert_mosi_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_rise |=> $stable(mosi));

  assert_cs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(cs_n));

endmodule

bind spi_chain_loader spi_loader_checker #(
  .DATA_W(DATA_W), .CHAINS(CHAINS), .ADDR_W(ADDR_W), .LEN_A(WORDS + 1)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_ack(bus_ack), .bus_nomore(bus_nomore), .busy(busy),
  .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n),
  .start_evt(start_evt), .bit_rise(bit_rise)
);

// File: tb/spi_chain_loader_tb.sv
module spi_chain_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF   = 3;
  localparam int W      = 32;
  localparam int DEPTH  = 16;
  localparam int CHAINS = 16;
  localparam int AW     = 5;
  localparam int MASK_A = 16;
  localparam int LEN_A  = 17;
  localparam int STAT_A = 18;

  logic clk = 0;
  logic rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic bus_ack, bus_nomore, busy, spi_sck, spi_mosi;
  logic [CHAINS-1:0] spi_cs_n;

  spi_chain_loader #(.DATA_W(W), .WORDS(DEPTH), .CHAINS(CHAINS), .SCK_HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_nomore(bus_nomore),
    .busy(busy), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] td [DEPTH];
  logic [CHAINS-1:0] tmask;
  logic expb [512];
  logic cap [512];

  // port monitor, sampled between edges
  int cyc = 0, nr = 0, t_start = 0, t_rise = 0, t_fall = 0, t_csr = 0, t_end = 0, lead = 0;
  int bad_cs = 0, bad_hi = 0, bad_lo = 0, bad_mosi = 0;
  bit mon_done = 0;
  logic [CHAINS-1:0] mon_exp_cs = '1;
  logic p_busy = 0, p_sck = 0, p_mosi = 0;
  logic [CHAINS-1:0] p_cs = '1;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (busy && !p_busy) begin
      t_start = cyc; nr = 0; mon_done = 0; lead = -1;
      bad_cs = 0; bad_hi = 0; bad_lo = 0; bad_mosi = 0;
    end
    if (spi_sck && !p_sck) begin
      if (nr == 0) lead = cyc - t_start;
      else if (cyc - t_fall != HALF) bad_lo++;
      if (nr < 512) cap[nr] = spi_mosi;
      if (spi_cs_n != mon_exp_cs) bad_cs++;
      nr++;
      t_rise = cyc;
    end
    if (!spi_sck && p_sck) begin
      if (cyc - t_rise != HALF) bad_hi++;
      t_fall = cyc;
    end
    if (spi_sck && p_sck && spi_mosi != p_mosi) bad_mosi++;
    if ((&spi_cs_n) && !(&p_cs)) t_csr = cyc;
    if (!busy && p_busy) begin t_end = cyc; mon_done = 1; end
    p_busy = busy; p_sck = spi_sck; p_mosi = spi_mosi; p_cs = spi_cs_n;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // caller is at a falling edge; request is seen at the next rising edge, answer read after it
  task automatic bus_write(input int addr, input logic [W-1:0] data, output bit a, output bit n);
    bus_wr = 1; bus_addr = AW'(addr); bus_wdata = data;
    @(negedge clk);
    a = bus_ack; n = bus_nomore;
    bus_wr = 0;
  endtask

  task automatic bus_read(input int addr, output logic [W-1:0] data, output bit a);
    bus_rd = 1; bus_addr = AW'(addr);
    @(negedge clk);
    a = bus_ack; data = bus_rdata;
    bus_rd = 0;
  endtask

  function automatic int eff_words(input int req);
    return (req > DEPTH) ? DEPTH : req;
  endfunction

  task automatic build_expect(input int words);
    for (int wi = 0; wi < words; wi++)
      for (int b = W - 1; b >= 0; b--)
        expb[wi*W + (W-1-b)] = td[wi][b];
  endtask

  // mode 0: plain, 1: refused count write mid-burst, 2: rewrite store and mask mid-burst
  task automatic run_burst(input int lenval, input bit setup, input int mode, input string tag);
    bit a, n, all_ack;
    int words, errs, first_bad;
    logic [W-1:0] rd;
    words = eff_words(lenval);
    build_expect(words);
    mon_exp_cs = ~tmask;
    all_ack = 1;
    if (setup) begin
      for (int i = 0; i < DEPTH; i++) begin
        bus_write(i, td[i], a, n);
        all_ack &= a;
      end
      bus_write(MASK_A, W'(tmask), a, n);
      all_ack &= a;
      chk(all_ack, {tag, " R12 setup writes acked"}, all_ack, 1);
    end
    bus_write(LEN_A, W'(lenval), a, n);
    chk(a && !n, {tag, " R3 count write acked"}, {a, n}, 2'b10);
    chk(busy === 1'b1, {tag, " R3 busy with ack"}, busy, 1);
    if (mode == 1) begin
      repeat (20) @(negedge clk);
      bus_write(LEN_A, 32'd5, a, n);
      chk(!a && n, {tag, " R4 refused while busy"}, {a, n}, 2'b01);
      bus_read(STAT_A, rd, a);
      chk(a && rd == 32'd1, {tag, " R2 status busy"}, rd, 1);
    end
    if (mode == 2) begin
      repeat (20) @(negedge clk);
      bus_write(0, ~td[0], a, n);
      bus_write(MASK_A, W'(~tmask), a, n);
    end
    do @(negedge clk); while (!mon_done);
    chk(nr == words * W, {tag, " R6 edge count"}, nr, words * W);
    errs = 0; first_bad = -1;
    for (int k = 0; k < words * W; k++)
      if (cap[k] !== expb[k]) begin
        errs++;
        if (first_bad < 0) first_bad = k;
      end
    chk(errs == 0, {tag, " R6 bit stream (first bad index)"}, first_bad, -1);
    chk(bad_cs == 0, {tag, " R8 select pattern"}, bad_cs, 0);
    chk(lead == HALF, {tag, " R8 select lead"}, lead, HALF);
    chk(t_csr - t_fall == HALF, {tag, " R8 select tail"}, t_csr - t_fall, HALF);
    chk(bad_hi == 0 && bad_lo == 0, {tag, " R9 phase widths"}, bad_hi + bad_lo, 0);
    chk(bad_mosi == 0, {tag, " R7 data stable while clock high"}, bad_mosi, 0);
    chk(t_end - t_csr == 2 * HALF, {tag, " R10 idle gap"}, t_end - t_csr, 2 * HALF);
    if (mode == 2) begin
      td[0] = ~td[0];
      tmask = ~tmask;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit a, n;
    logic [W-1:0] rd;
    void'($urandom(32'h5eed_c0de));
    repeat (4) @(negedge clk);
    chk(spi_cs_n === '1 && spi_sck === 1'b0 && busy === 1'b0, "R1 reset state",
        {spi_cs_n, spi_sck, busy}, {16'hffff, 2'b00});
    rst_n = 1;
    @(negedge clk);

    // R2 register map readback
    bus_write(5, 32'hdead_beef, a, n);
    chk(a && !n, "R2 data write ack", {a, n}, 2'b10);
    bus_read(5, rd, a);
    chk(a && rd == 32'hdead_beef, "R2 data readback", rd, 32'hdead_beef);
    bus_write(MASK_A, 32'h0000_1234, a, n);
    bus_read(MASK_A, rd, a);
    chk(rd == 32'h1234, "R2 mask readback", rd, 32'h1234);
    bus_read(STAT_A, rd, a);
    chk(a && rd == 0, "R2 status idle", rd, 0);

    // R5 zero count
    bus_write(LEN_A, 32'd0, a, n);
    chk(a && !n, "R5 zero count acked", {a, n}, 2'b10);
    repeat (10) @(negedge clk);
    chk(busy === 1'b0 && spi_cs_n === '1 && spi_sck === 1'b0, "R5 nothing started",
        {busy, spi_cs_n, spi_sck}, {1'b0, 16'hffff, 1'b0});

    // directed: single word, one chain
    for (int i = 0; i < DEPTH; i++) td[i] = 32'h0;
    td[0] = 32'ha5c3_0f81; tmask = 16'h0001;
    run_burst(1, 1, 0, "single");

    // full chain on all selects
    for (int i = 0; i < DEPTH; i++) td[i] = 32'h0101_0101 * (i + 1) ^ 32'h8000_0001;
    tmask = 16'hffff;
    run_burst(16, 1, 0, "full");

    // count above the store size saturates to 16
    tmask = 16'h8001;
    run_burst(20, 1, 0, "clamp R3");

    // refused count write during a burst
    tmask = 16'h00f0;
    run_burst(6, 1, 1, "refuse R4");

    // snapshot then reuse without rewriting the store
    for (int i = 0; i < DEPTH; i++) td[i] = $urandom;
    tmask = 16'h0c30;
    run_burst(3, 1, 2, "snapshot R11");
    run_burst(3, 0, 0, "after-rewrite R11");

    // random bursts
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < DEPTH; i++) td[i] = $urandom;
      tmask = CHAINS'($urandom_range(1, 16'hffff));
      run_burst($urandom_range(1, 16), 1, 0, "random");
    end

    chk(busy === 1'b0 && spi_cs_n === '1 && spi_sck === 1'b0, "R1 idle after bursts",
        {busy, spi_cs_n, spi_sck}, {1'b0, 16'hffff, 1'b0});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule